// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block performs the architectural state change that happens when a processor core takes a trap. Each cycle it may receive one trap request: an exception or an interrupt, carrying a cause code, the faulting address and the program counter of the trapping instruction. It also receives the current privilege level, the exception and interrupt delegation masks, the supervisor and machine vector bases, and the current status word. From these it picks the privilege level that will handle the trap. It then writes that level's cause, exception-PC and bad-address registers, and returns a new PC, a new status word and a new privilege mode.

The unit corrects an environment-call cause so that it names the privilege level the call came from. A trap goes to supervisor only when the current level is supervisor or lower and the matching delegation bit is set; every other trap goes to machine. The bad-address register is loaded only for address-related exceptions. The parent pipeline takes the registered redirect and the status write-back on the cycle after the request. Trap return, vectored dispatch and software access to the registers are handled elsewhere.

Top module: `trap_entry_unit`

## Requirements
- R1: A trap sampled with `trap_valid` high at a rising edge commits all of its updates at that same edge. `redirect_valid` and `status_we` are high for exactly the following cycle. With `trap_valid` low, both are low and no held register changes.
- R2: For an interrupt, the written cause word has bit XLEN-1 set and the interrupt number in the low bits, with zeros in between.
- R3: Privilege encoding is user=0, supervisor=1, machine=3. An exception with code 8 (environment call) is written as cause 8 from user, 9 from supervisor and 11 from machine. Any other exception code is written unchanged.
- R4: The trap goes to supervisor when `cur_priv` is 0 or 1 and bit [corrected cause code] of the delegation mask is set. Interrupts index `irq_deleg`. Exceptions index `exc_deleg`.
- R5: Every other trap goes to machine. A trap taken while `cur_priv` is 3 always goes to machine, whatever the masks hold.
- R6: A supervisor trap loads the redirect PC from `svec_base` and writes `s_cause`, and writes `s_epc` from `trap_pc`. In the status word (SIE bit 1, SPIE bit 5, SPP bit 8), SPIE takes the old SIE, SPP takes bit 0 of the old privilege and SIE is cleared. `priv_mode` becomes 1.
- R7: A machine trap loads the redirect PC from `mvec_base` and writes `m_cause`, and writes `m_epc` from `trap_pc`. In the status word (MIE bit 3, MPIE bit 7, MPP bits 12:11), MPIE takes the old MIE, MPP takes the old privilege and MIE is cleared. `priv_mode` becomes 3. All status bits not named in R6 or R7 pass through unchanged.
- R8: The target level's bad-address register is loaded from `trap_addr` only for exception causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. For other exception causes and for interrupts it keeps its value. The registers of the non-target level never change.
- R9: After a synchronous active-low reset, `priv_mode` is 3 (machine), all cause, EPC and bad-address registers are zero, and `redirect_valid` and `status_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_valid | input | 1 | Trap request strobe |
| trap_irq | input | 1 | Request is an interrupt (1) or exception (0) |
| trap_code | input | CODE_W | Raw cause code / interrupt number |
| trap_addr | input | XLEN | Faulting address |
| trap_pc | input | XLEN | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege level |
| exc_deleg | input | XLEN | Exception delegation mask |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| svec_base | input | XLEN | Supervisor trap vector |
| mvec_base | input | XLEN | Machine trap vector |
| status_in | input | XLEN | Current status word |
| redirect_valid | output | 1 | New PC is valid this cycle |
| redirect_pc | output | XLEN | New PC |
| status_we | output | 1 | Status write-back strobe |
| status_wdata | output | XLEN | Updated status word |
| priv_mode | output | 2 | Privilege after the last trap |
| s_cause | output | XLEN | Supervisor cause register |
| s_epc | output | XLEN | Supervisor exception PC |
| s_tval | output | XLEN | Supervisor bad-address register |
| m_cause | output | XLEN | Machine cause register |
| m_epc | output | XLEN | Machine exception PC |
| m_tval | output | XLEN | Machine bad-address register |

## Verification
The bench builds the unit with its default XLEN of 32, which gives a 5-bit cause code. Every one of the 32 delegation bits can therefore be reached, including the boundary code 31 and the interrupt flag at bit 31. At this width the cause word can also be compared exactly by hand. The bench sends back-to-back traps and traps from all three privilege levels. It sweeps all sixteen low exception codes, so that every cause that loads the bad-address register and every cause that does not is covered.

// File: rtl/trap_pkg.sv
// Shared definitions for the trap entry unit.
// Assumes the status word layout and privilege encoding given in the brief.
package trap_pkg;
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int ECALL_BASE = 8;

    // status word bit positions decoded by the surrounding core
    localparam int ST_SIE   = 1;
    localparam int ST_MIE   = 3;
    localparam int ST_SPIE  = 5;
    localparam int ST_MPIE  = 7;
    localparam int ST_SPP   = 8;
    localparam int ST_MPP_LO = 11;
    localparam int ST_MPP_HI = 12;

    // Level index used for the per-level register banks
    localparam int LVL_S = 0;
    localparam int LVL_M = 1;
    localparam int NUM_LEVELS = 2;

    // True for exception causes that report a faulting address
    function automatic logic cause_has_addr(input int unsigned code);
        case (code)
            0, 1, 4, 5, 6, 7, 12, 13, 15: cause_has_addr = 1'b1;
            default:                      cause_has_addr = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/trap_cause_fixup.sv
// Cause correction: rewrites the environment-call code by privilege,
// builds the cause word, and flags causes that record a bad address.
// Assumes CODE_W >= 4 and CODE_W < XLEN.
module trap_cause_fixup #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic              is_irq,
    input  logic [CODE_W-1:0] raw_code,
    input  logic [1:0]        priv,
    output logic [CODE_W-1:0] fixed_code,
    output logic [XLEN-1:0]   cause_word,
    output logic              keep_addr
);
    import trap_pkg::*;

    // Correct an environment call to name the calling privilege
    always_comb begin
        fixed_code = raw_code;
        if (!is_irq && raw_code == CODE_W'(ECALL_BASE))
            fixed_code = CODE_W'(ECALL_BASE) + CODE_W'(priv);
    end

    // Assemble the architectural cause word
    always_comb begin
        cause_word                = '0;
        cause_word[CODE_W-1:0]    = fixed_code;
        cause_word[XLEN-1]        = is_irq;
    end

    // Only address-related exceptions capture the faulting address
    always_comb keep_addr = !is_irq && cause_has_addr(int'(fixed_code));
endmodule

// File: rtl/trap_router.sv
// Delegation decision: selects supervisor or machine as the trap target.
// Assumes the delegation masks are XLEN wide and the code indexes them.
module trap_router #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic              is_irq,
    input  logic [CODE_W-1:0] fixed_code,
    input  logic [1:0]        priv,
    input  logic [XLEN-1:0]   exc_mask,
    input  logic [XLEN-1:0]   irq_mask,
    output logic              to_super
);
    import trap_pkg::*;

    logic [XLEN-1:0] mask_sel;
    logic            low_priv;

    // Pick the mask belonging to the trap kind
    always_comb mask_sel = is_irq ? irq_mask : exc_mask;

    // Delegation only applies from supervisor or user
    always_comb low_priv = (priv == PRIV_U) || (priv == PRIV_S);

    // Route to supervisor when permitted and the mask bit is set
    always_comb to_super = low_priv && mask_sel[fixed_code];
endmodule

// File: rtl/trap_status_stack.sv
// Status stacking: pushes the interrupt enable and privilege of the
// target level into their previous-state fields and clears the enable.
// Assumes the bit positions of trap_pkg; other bits pass through.
module trap_status_stack #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] status_old,
    input  logic [1:0]      priv,
    input  logic            to_super,
    output logic [XLEN-1:0] status_new
);
    import trap_pkg::*;

    // Build the updated status word for the chosen level
    always_comb begin
        status_new = status_old;
        if (to_super) begin
            status_new[ST_SPIE] = status_old[ST_SIE];
            status_new[ST_SPP]  = priv[0];
            status_new[ST_SIE]  = 1'b0;
        end else begin
            status_new[ST_MPIE] = status_old[ST_MIE];
            status_new[ST_MPP_HI:ST_MPP_LO] = priv;
            status_new[ST_MIE]  = 1'b0;
        end
    end
endmodule

// File: rtl/trap_level_regs.sv
// Per-level trap registers: cause, exception PC and bad address.
// Assumes at most one level is written in any cycle.
module trap_level_regs #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_addr_en,
    input  logic [XLEN-1:0] cause_in,
    input  logic [XLEN-1:0] epc_in,
    input  logic [XLEN-1:0] addr_in,
    output logic [XLEN-1:0] cause_q,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] tval_q
);
    // Capture cause and EPC on every trap aimed at this level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            epc_q   <= '0;
        end else if (wr_en) begin
            cause_q <= cause_in;
            epc_q   <= epc_in;
        end
    end

    // Capture the faulting address only for address-related causes
    always_ff @(posedge clk) begin
        if (!rst_n)
            tval_q <= '0;
        else if (wr_en && wr_addr_en)
            tval_q <= addr_in;
    end
endmodule

// File: rtl/trap_entry_unit.sv
// Trap entry unit top: decodes, routes and commits a trap in one cycle.
// Assumes at most one trap request per cycle; synchronous active-low reset.
module trap_entry_unit #(
    parameter int XLEN   = 32,
    parameter int CODE_W = $clog2(XLEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_valid,
    input  logic              trap_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   trap_addr,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic [1:0]        cur_priv,
    input  logic [XLEN-1:0]   exc_deleg,
    input  logic [XLEN-1:0]   irq_deleg,
    input  logic [XLEN-1:0]   svec_base,
    input  logic [XLEN-1:0]   mvec_base,
    input  logic [XLEN-1:0]   status_in,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              status_we,
    output logic [XLEN-1:0]   status_wdata,
    output logic [1:0]        priv_mode,
    output logic [XLEN-1:0]   s_cause,
    output logic [XLEN-1:0]   s_epc,
    output logic [XLEN-1:0]   s_tval,
    output logic [XLEN-1:0]   m_cause,
    output logic [XLEN-1:0]   m_epc,
    output logic [XLEN-1:0]   m_tval
);
    import trap_pkg::*;

    logic [CODE_W-1:0] fixed_code;
    logic [XLEN-1:0]   cause_word;
    logic              keep_addr;
    logic              to_super;
    logic [XLEN-1:0]   status_next;

    logic [XLEN-1:0]   lvl_cause [NUM_LEVELS];
    logic [XLEN-1:0]   lvl_epc   [NUM_LEVELS];
    logic [XLEN-1:0]   lvl_tval  [NUM_LEVELS];

    trap_cause_fixup #(.XLEN(XLEN), .CODE_W(CODE_W)) u_fixup (
        .is_irq     (trap_irq),
        .raw_code   (trap_code),
        .priv       (cur_priv),
        .fixed_code (fixed_code),
        .cause_word (cause_word),
        .keep_addr  (keep_addr)
    );

    trap_router #(.XLEN(XLEN), .CODE_W(CODE_W)) u_router (
        .is_irq     (trap_irq),
        .fixed_code (fixed_code),
        .priv       (cur_priv),
        .exc_mask   (exc_deleg),
        .irq_mask   (irq_deleg),
        .to_super   (to_super)
    );

    trap_status_stack #(.XLEN(XLEN)) u_stack (
        .status_old (status_in),
        .priv       (cur_priv),
        .to_super   (to_super),
        .status_new (status_next)
    );

    // One register bank per handling level
    for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_level
        logic hit;
        // Select this bank when the routed target matches its level
        always_comb hit = trap_valid && (to_super == (lv == LVL_S));

        trap_level_regs #(.XLEN(XLEN)) u_regs (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (hit),
            .wr_addr_en (keep_addr),
            .cause_in   (cause_word),
            .epc_in     (trap_pc),
            .addr_in    (trap_addr),
            .cause_q    (lvl_cause[lv]),
            .epc_q      (lvl_epc[lv]),
            .tval_q     (lvl_tval[lv])
        );
    end

    // Issue the PC redirect and status write-back one cycle after a trap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            status_we      <= 1'b0;
            status_wdata   <= '0;
        end else begin
            redirect_valid <= trap_valid;
            status_we      <= trap_valid;
            if (trap_valid) begin
                redirect_pc  <= to_super ? svec_base : mvec_base;
                status_wdata <= status_next;
            end
        end
    end

    // Track the privilege entered by the last trap; reset enters machine
    always_ff @(posedge clk) begin
        if (!rst_n)
            priv_mode <= PRIV_M;
        else if (trap_valid)
            priv_mode <= to_super ? PRIV_S : PRIV_M;
    end

    // Expose the bank contents under their architectural names
    always_comb begin
        s_cause = lvl_cause[LVL_S];
        s_epc   = lvl_epc[LVL_S];
        s_tval  = lvl_tval[LVL_S];
        m_cause = lvl_cause[LVL_M];
        m_epc   = lvl_epc[LVL_M];
        m_tval  = lvl_tval[LVL_M];
    end
endmodule

// File: rtl/trap_entry_checker.sv
// Protocol checks for trap_entry_unit, attached by bind.
module trap_entry_checker #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trap_valid,
    input logic              trap_irq,
    input logic [CODE_W-1:0] trap_code,
    input logic [1:0]        cur_priv,
    input logic [XLEN-1:0]   mvec_base,
    input logic              redirect_valid,
    input logic [XLEN-1:0]   redirect_pc,
    input logic              status_we,
    input logic [XLEN-1:0]   status_wdata,
    input logic [1:0]        priv_mode,
    input logic [XLEN-1:0]   s_cause,
    input logic [XLEN-1:0]   s_tval,
    input logic [XLEN-1:0]   m_cause,
    input logic [XLEN-1:0]   m_tval
);
    // R1
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> redirect_valid && status_we);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |=> !redirect_valid && !status_we && $stable(priv_mode));
    // R5
    machine_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && cur_priv == 2'd3 |=> priv_mode == 2'd3 && redirect_pc == $past(mvec_base));
    // R2
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && trap_irq |=> (priv_mode == 2'd1) ? s_cause[XLEN-1] : m_cause[XLEN-1]);
    // R6
    sie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_we && priv_mode == 2'd1 |-> !status_wdata[1]);
    // R7
    mie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_we && priv_mode == 2'd3 |-> !status_wdata[3]);
    // R8
    irq_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && trap_irq |=> $stable(s_tval) && $stable(m_tval));
    // R8
    illegal_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && !trap_irq && trap_code == CODE_W'(2) |=> $stable(s_tval) && $stable(m_tval));
endmodule

bind trap_entry_unit trap_entry_checker #(.XLEN(XLEN), .CODE_W(CODE_W)) u_trap_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .trap_valid     (trap_valid),
    .trap_irq       (trap_irq),
    .trap_code      (trap_code),
    .cur_priv       (cur_priv),
    .mvec_base      (mvec_base),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .status_we      (status_we),
    .status_wdata   (status_wdata),
    .priv_mode      (priv_mode),
    .s_cause        (s_cause),
    .s_tval         (s_tval),
    .m_cause        (m_cause),
    .m_tval         (m_tval)
);

// File: tb/tb_trap_entry_unit.sv
// Scoreboard bench: the driver predicts each trap's outcome into a queue;
// the monitor pops and compares whenever the unit signals a redirect.
module tb_trap_entry_unit;
    localparam int XLEN = 32;
    localparam int CW   = 5;
    localparam logic [XLEN-1:0] SVEC = 32'h0000_1100;
    localparam logic [XLEN-1:0] MVEC = 32'h0000_2200;

    typedef struct {
        logic [XLEN-1:0] pc, st, sc, se, stv, mc, me, mtv;
        logic [1:0]      pv;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trap_valid = 1'b0, trap_irq = 1'b0;
    logic [CW-1:0]   trap_code = '0;
    logic [XLEN-1:0] trap_addr = '0, trap_pc = '0;
    logic [1:0]      cur_priv = 2'd3;
    logic [XLEN-1:0] exc_deleg = '0, irq_deleg = '0, status_in = '0;
    logic            redirect_valid, status_we;
    logic [XLEN-1:0] redirect_pc, status_wdata;
    logic [1:0]      priv_mode;
    logic [XLEN-1:0] s_cause, s_epc, s_tval, m_cause, m_epc, m_tval;

    int n_chk = 0, n_bad = 0;
    exp_t q[$];
    exp_t mdl;

    always #2.5 clk = ~clk;

    trap_entry_unit #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_irq(trap_irq),
        .trap_code(trap_code), .trap_addr(trap_addr), .trap_pc(trap_pc),
        .cur_priv(cur_priv), .exc_deleg(exc_deleg), .irq_deleg(irq_deleg),
        .svec_base(SVEC), .mvec_base(MVEC), .status_in(status_in),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .status_we(status_we), .status_wdata(status_wdata), .priv_mode(priv_mode),
        .s_cause(s_cause), .s_epc(s_epc), .s_tval(s_tval),
        .m_cause(m_cause), .m_epc(m_epc), .m_tval(m_tval));

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one trap at a falling edge and push its predicted outcome
    task automatic drive(input logic irq, input int code, input logic [XLEN-1:0] addr,
                         input logic [XLEN-1:0] pc, input logic [1:0] pv,
                         input logic [XLEN-1:0] ed, input logic [XLEN-1:0] id,
                         input logic [XLEN-1:0] st);
        int fc;
        logic sup, keep;
        logic [XLEN-1:0] cause, dm;
        @(negedge clk);
        trap_valid = 1'b1; trap_irq = irq; trap_code = CW'(code); trap_addr = addr;
        trap_pc = pc; cur_priv = pv; exc_deleg = ed; irq_deleg = id; status_in = st;
        fc = code;
        if (!irq && code == 8) fc = 8 + int'(pv);            // R3 correction
        cause = irq ? (32'h8000_0000 | XLEN'(fc)) : XLEN'(fc); // R2
        dm = irq ? id : ed;
        sup = (pv <= 2'd1) && dm[fc];                          // R4 / R5
        keep = !irq && (fc inside {0, 1, 4, 5, 6, 7, 12, 13, 15}); // R8
        mdl.st = st;
        if (sup) begin
            mdl.pc = SVEC; mdl.sc = cause; mdl.se = pc; mdl.pv = 2'd1;
            if (keep) mdl.stv = addr;
            mdl.st[5] = st[1]; mdl.st[8] = pv[0]; mdl.st[1] = 1'b0;
        end else begin
            mdl.pc = MVEC; mdl.mc = cause; mdl.me = pc; mdl.pv = 2'd3;
            if (keep) mdl.mtv = addr;
            mdl.st[7] = st[3]; mdl.st[12:11] = pv; mdl.st[3] = 1'b0;
        end
        q.push_back(mdl);
    endtask

    task automatic idle();
        @(negedge clk);
        trap_valid = 1'b0;
    endtask

    // Monitor: compare every redirect against the oldest prediction
    always @(negedge clk) begin
        if (rst_n && redirect_valid) begin
            if (q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R1 actual=redirect expected=none");
            end else begin
                exp_t e;
                e = q.pop_front();
                chk("R6/R7 pc", redirect_pc, e.pc);
                chk("R6/R7 status", status_wdata, e.st);
                chk("R4/R5 priv", {30'd0, priv_mode}, {30'd0, e.pv});
                chk("R2/R3 s_cause", s_cause, e.sc);
                chk("R6 s_epc", s_epc, e.se);
                chk("R8 s_tval", s_tval, e.stv);
                chk("R2/R3 m_cause", m_cause, e.mc);
                chk("R7 m_epc", m_epc, e.me);
                chk("R8 m_tval", m_tval, e.mtv);
                chk("R1 status_we", {31'd0, status_we}, 32'd1);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        mdl = '{default: '0};
        mdl.pv = 2'd3;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 priv", {30'd0, priv_mode}, 32'd3);
        chk("R9 redirect", {31'd0, redirect_valid}, 32'd0);
        chk("R9 m_cause", m_cause, 32'd0);
        chk("R9 s_tval", s_tval, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R9 status_we", {31'd0, status_we}, 32'd0);

        // R3/R5: ecall from machine with all delegation set -> machine, cause 11
        drive(0, 8, 32'hA0, 32'h100, 2'd3, '1, '1, 32'h0000_0008);
        // R3/R4/R6: ecall from user delegated -> supervisor, cause 8
        drive(0, 8, 32'hA1, 32'h104, 2'd0, 32'h0000_0100, '0, 32'h0000_0002);
        idle();
        // R3/R5/R7: ecall from supervisor, bit 9 clear -> machine, cause 9
        drive(0, 8, 32'hA2, 32'h108, 2'd1, 32'h0000_0100, '0, 32'hFFFF_FFFF);
        // R4/R8: load page fault from supervisor delegated -> s_tval written
        drive(0, 13, 32'hDEAD_0000, 32'h10C, 2'd1, 32'h0000_2000, '0, 32'h0000_0002);
        idle();
        // R2/R4: interrupt 5 uses irq mask
        drive(1, 5, 32'hBAD0, 32'h110, 2'd0, '0, 32'h0000_0020, 32'h0000_0002);
        // R4/R5: interrupt 5 with only exception bit set -> machine
        drive(1, 5, 32'hBAD1, 32'h114, 2'd0, 32'h0000_0020, '0, 32'h0000_0008);
        idle();
        // R8: sweep low exception codes to machine, new address each time
        for (int c = 0; c < 16; c++) begin
            drive(0, c, 32'h5000 + XLEN'(c), 32'h200 + XLEN'(c), 2'd3, '0, '0, 32'h0000_1888);
            idle();
        end
        // R8 sweep to supervisor as well
        for (int c = 0; c < 16; c++) begin
            if (c == 8) continue;
            drive(0, c, 32'h6000 + XLEN'(c), 32'h300 + XLEN'(c), 2'd0, '1, '0, 32'h0000_0000);
        end
        idle();
        // R4 boundary: exception code 31 delegated from user
        drive(0, 31, 32'h7000, 32'h400, 2'd0, 32'h8000_0000, '0, 32'h0);
        // R2 boundary: interrupt 31 delegated from supervisor
        drive(1, 31, 32'h7001, 32'h404, 2'd1, '0, 32'h8000_0000, 32'h0000_0122);
        // R5: interrupt from machine ignores irq mask
        drive(1, 7, 32'h7002, 32'h408, 2'd3, '1, '1, 32'h0000_0088);
        idle();
        repeat (3) @(negedge clk);
        // R1: every prediction consumed, nothing extra
        chk("R1 queue drained", XLEN'(q.size()), 32'd0);
        chk("R1 idle redirect", {31'd0, redirect_valid}, 32'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule